// File: doc/BRIEF.md
# Vector Float-to-Word Truncating Converter

This block takes a 128-bit operand holding four single-precision floating-point lanes and turns each lane into a 32-bit integer in the same lane position. Every conversion rounds toward zero. The `in_uns` select chooses between two's-complement signed results and unsigned results for the whole operand. Inputs that cannot be represented do not wrap. They saturate to fixed encodings and raise an invalid-conversion flag. Signaling NaNs also raise a signaling-NaN flag, and lost fractional bits raise an inexact flag.

Operands enter through a valid/ready handshake. Each result leaves through a second valid/ready handshake, together with a 3-bit flag vector that is the OR of the per-lane flags. The block has two register stages, so a result appears two clock cycles after its operand is accepted, and a new operand can be accepted in every cycle. When the consumer holds `out_ready` low, the whole pipeline freezes and `in_ready` drops.

Top module: `vfw_trunc_cvt`

## Requirements
- R1: Lane i of the result (bits 32i+31..32i) comes only from lane i of the operand. The magnitude is truncated toward zero, so 12345.98 gives 12345 and -2.5 gives -2 (0xFFFFFFFE) in signed mode.
- R2: In signed mode, a NaN lane gives 0x80000000 and sets the invalid flag, `out_flags` bit 0.
- R3: A signaling NaN (quiet bit, mantissa bit 22, clear) sets the signaling-NaN flag, `out_flags` bit 1, as well as the invalid flag. A quiet NaN leaves bit 1 clear.
- R4: In signed mode, values whose truncation exceeds 2^31-1 give 0x7FFFFFFF, and values below -2^31 give 0x80000000, both with the invalid flag set. +infinity and -infinity saturate the same way by sign. -2^31 itself converts exactly, with no flag.
- R5: In unsigned mode, a NaN lane, a lane that is infinite and negative, or a negative lane whose truncation is nonzero gives 0x00000000 with the invalid flag set. Values of 2^32 or more, including +infinity, give 0xFFFFFFFF with the invalid flag set. Values up to 0xFFFFFF00 convert exactly.
- R6: In unsigned mode, a negative lane greater than -1.0 gives 0 without the invalid flag. It sets inexact when its value is nonzero, and -0.0 sets no flag.
- R7: The inexact flag, `out_flags` bit 2, is set when a lane that is not invalid loses nonzero fractional bits. Exact conversions and saturated invalid lanes do not set it.
- R8: Zero and denormal lanes give 0. A denormal lane sets inexact and a zero lane sets no flag.
- R9: Each flag bit is the OR of that flag over all four lanes, and it is presented in the same cycle as the result it belongs to.
- R10: A result appears with `out_valid` two cycles after its operand is accepted. Back-to-back operands give back-to-back results. While `out_valid` is high and `out_ready` is low, the result and flags hold steady and `in_ready` is low.
- R11: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand valid |
| in_ready | output | 1 | Operand accepted when high together with in_valid |
| in_opnd | input | 128 | Four single-precision lanes, lane 0 in bits 31..0 |
| in_uns | input | 1 | 1 selects unsigned results, 0 selects signed results |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result when high |
| out_result | output | 128 | Four 32-bit integer lanes, lane 0 in bits 31..0 |
| out_flags | output | 3 | bit 0 invalid, bit 1 signaling NaN, bit 2 inexact, each ORed over lanes |

## Verification
The main conversion is driven with a mix of fractional, exact, and power-of-two operands placed in different lanes. A lane swap, a wrong truncation direction, or an off-by-one saturation threshold therefore shows up as a wrong lane value. Boundary operands sit on each side of the threshold: 2^31-128, -2^31, 2^31, 2^32 and 0xFFFFFF00 separate the signed and unsigned saturation points. Quiet and signaling NaNs are placed in different lanes to separate the invalid flag from the signaling-NaN flag and to show that the flags are ORed across lanes. Small negatives, -0.0 and denormals are used in unsigned mode to separate the truncate-to-zero case from the invalid negative case. A back-to-back stream and a stalled consumer check the two-cycle latency and the freeze under backpressure.

// File: rtl/vfw_pkg.sv
package vfw_pkg;
    // single-precision field layout
    localparam int FP_W   = 32;
    localparam int EXP_W  = 8;
    localparam int MAN_W  = 23;
    localparam int BIAS   = 127;
    // flag vector layout
    localparam int FLG_W    = 3;
    localparam int FLG_INV  = 0;
    localparam int FLG_SNAN = 1;
    localparam int FLG_INX  = 2;

    typedef logic [FLG_W-1:0] cvt_flags_t;
endpackage

// File: rtl/vfw_lane_cvt.sv
module vfw_lane_cvt
    import vfw_pkg::*;
(
    input  logic [FP_W-1:0] opnd,
    input  logic            uns,
    output logic [FP_W-1:0] res,
    output cvt_flags_t      flg
);
    localparam int SIG_W = MAN_W + 1;
    localparam int FIX_W = SIG_W + FP_W - 1;
    localparam int SH_W  = $clog2(FP_W);
    localparam logic [EXP_W-1:0] EXP_MAX = '1;
    localparam logic [FP_W-1:0]  SMAX    = {1'b0, {(FP_W-1){1'b1}}};
    localparam logic [FP_W-1:0]  SMIN    = {1'b1, {(FP_W-1){1'b0}}};
    localparam logic [FP_W-1:0]  UMAX    = '1;

    logic             sgn;
    logic [EXP_W-1:0] expo;
    logic [MAN_W-1:0] man;
    logic [EXP_W-1:0] ue;
    logic             ge_one;
    logic             in_win;
    logic [FIX_W-1:0] fixv;
    logic [FP_W-1:0]  mag;
    logic             lost;

    assign sgn    = opnd[FP_W-1];
    assign expo   = opnd[FP_W-2:MAN_W];
    assign man    = opnd[MAN_W-1:0];
    assign ue     = expo - EXP_W'(BIAS);
    assign ge_one = (expo >= EXP_W'(BIAS));
    assign in_win = ge_one && (ue[EXP_W-1:SH_W] == '0);
    assign fixv   = FIX_W'({1'b1, man}) << ue[SH_W-1:0];

    always_comb begin
        mag  = in_win ? fixv[FIX_W-1:MAN_W] : '0;
        lost = in_win ? (|fixv[MAN_W-1:0]) : (|{expo, man});
        res  = '0;
        flg  = '0;
        if (expo == EXP_MAX && man != '0) begin
            flg[FLG_INV]  = 1'b1;
            flg[FLG_SNAN] = !man[MAN_W-1];
            res           = uns ? '0 : SMIN;
        end else if (expo == EXP_MAX || (ge_one && !in_win)) begin
            flg[FLG_INV] = 1'b1;
            if (uns) res = sgn ? '0 : UMAX;
            else     res = sgn ? SMIN : SMAX;
        end else if (uns) begin
            if (sgn && mag != '0) begin
                flg[FLG_INV] = 1'b1;
            end else begin
                res          = mag;
                flg[FLG_INX] = lost;
            end
        end else begin
            if (!sgn && mag > SMAX) begin
                res          = SMAX;
                flg[FLG_INV] = 1'b1;
            end else if (sgn && mag > SMIN) begin
                res          = SMIN;
                flg[FLG_INV] = 1'b1;
            end else begin
                res          = sgn ? -mag : mag;
                flg[FLG_INX] = lost;
            end
        end
    end
endmodule

// File: rtl/vfw_flag_merge.sv
module vfw_flag_merge
    import vfw_pkg::*;
#(
    parameter int LANES = 4
) (
    input  cvt_flags_t [LANES-1:0] lane_flg,
    output cvt_flags_t             any_flg
);
    always_comb begin
        any_flg = '0;
        for (int i = 0; i < LANES; i++) begin
            any_flg = any_flg | lane_flg[i];
        end
    end
endmodule

// File: rtl/vfw_trunc_cvt.sv
module vfw_trunc_cvt
    import vfw_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [LANES*FP_W-1:0] in_opnd,
    input  logic                  in_uns,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [LANES*FP_W-1:0] out_result,
    output logic [FLG_W-1:0]      out_flags
);
    localparam int VEC_W = LANES * FP_W;

    logic [VEC_W-1:0]       lane_res;
    cvt_flags_t [LANES-1:0] lane_flg;
    logic [VEC_W-1:0]       s1_res;
    cvt_flags_t [LANES-1:0] s1_flg;
    logic                   s1_vld;
    cvt_flags_t             s1_any;
    logic [VEC_W-1:0]       s2_res;
    cvt_flags_t             s2_flg;
    logic                   s2_vld;
    logic                   adv;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        vfw_lane_cvt u_cvt (
            .opnd (in_opnd[g*FP_W +: FP_W]),
            .uns  (in_uns),
            .res  (lane_res[g*FP_W +: FP_W]),
            .flg  (lane_flg[g])
        );
    end

    vfw_flag_merge #(.LANES(LANES)) u_merge (
        .lane_flg (s1_flg),
        .any_flg  (s1_any)
    );

    assign adv = !s2_vld || out_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld <= 1'b0;
            s1_res <= '0;
            s1_flg <= '0;
            s2_vld <= 1'b0;
            s2_res <= '0;
            s2_flg <= '0;
        end else if (adv) begin
            s1_vld <= in_valid;
            s1_res <= lane_res;
            s1_flg <= lane_flg;
            s2_vld <= s1_vld;
            s2_res <= s1_res;
            s2_flg <= s1_any;
        end
    end

    always_comb begin
        in_ready   = adv;
        out_valid  = s2_vld;
        out_result = s2_res;
        out_flags  = s2_flg;
    end
endmodule

// File: rtl/vfw_trunc_cvt_chk.sv
module vfw_trunc_cvt_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         in_ready,
    input logic         out_valid,
    input logic         out_ready,
    input logic [127:0] out_result,
    input logic [2:0]   out_flags
);
    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_flags));

    // R10
    latency_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && in_ready) && in_ready |=> out_valid);

    // R3
    snan_implies_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_flags[1] |-> out_flags[0]);

    // R11
    idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    // R9
    known_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown({out_result, out_flags}));
endmodule

bind vfw_trunc_cvt vfw_trunc_cvt_chk chk_i (.*);

// File: tb/vfw_trunc_cvt_tb.sv
`timescale 1ns/1ps
module vfw_trunc_cvt_tb_top;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic         in_ready;
    logic [127:0] in_opnd;
    logic         in_uns;
    logic         out_valid;
    logic         out_ready;
    logic [127:0] out_result;
    logic [2:0]   out_flags;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    vfw_trunc_cvt dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_opnd(in_opnd), .in_uns(in_uns), .out_valid(out_valid),
        .out_ready(out_ready), .out_result(out_result), .out_flags(out_flags)
    );

    // operand encodings
    localparam logic [31:0] F_12345_98 = 32'h4640E7EC;
    localparam logic [31:0] F_ONE      = 32'h3F800000;
    localparam logic [31:0] F_M2_5     = 32'hC0200000;
    localparam logic [31:0] F_100      = 32'h42C80000;
    localparam logic [31:0] F_2P31     = 32'h4F000000;
    localparam logic [31:0] F_M2P31    = 32'hCF000000;
    localparam logic [31:0] F_M2P32    = 32'hCF800000;
    localparam logic [31:0] F_2P32     = 32'h4F800000;
    localparam logic [31:0] F_UTOP     = 32'h4F7FFFFF;
    localparam logic [31:0] F_STOP     = 32'h4EFFFFFF;
    localparam logic [31:0] F_PINF     = 32'h7F800000;
    localparam logic [31:0] F_NINF     = 32'hFF800000;
    localparam logic [31:0] F_QNAN     = 32'h7FC00000;
    localparam logic [31:0] F_SNAN     = 32'h7F800001;
    localparam logic [31:0] F_MHALF    = 32'hBF000000;
    localparam logic [31:0] F_MZERO    = 32'h80000000;
    localparam logic [31:0] F_DEN      = 32'h00000001;
    localparam logic [31:0] F_MDEN     = 32'h80000001;
    localparam logic [31:0] F_MONE     = 32'hBF800000;

    function automatic logic [127:0] pk(input logic [31:0] l0, l1, l2, l3);
        return {l3, l2, l1, l0};
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp_v);
        n_run++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp_v);
        end
    endtask

    task automatic run_op(input string req, input logic [127:0] op, input logic u,
                          input logic [127:0] exp_r, input logic [2:0] exp_f);
        @(negedge clk);
        in_valid = 1'b1; in_opnd = op; in_uns = u;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check(req, 128'(out_valid), 128'(1'b1));
        check(req, out_result, exp_r);
        check(req, 128'(out_flags), 128'(exp_f));
    endtask

    task automatic t_reset;
        check("R11", 128'(out_valid), 128'(1'b0));
        check("R11", 128'(in_ready), 128'(1'b1));
    endtask

    task automatic t_basic;
        // R1 R7: truncation per lane, inexact from fractional lanes
        run_op("R1", pk(F_12345_98, F_ONE, F_M2_5, F_100), 1'b0,
               pk(32'd12345, 32'd1, 32'hFFFFFFFE, 32'd100), 3'b100);
        run_op("R1", pk(F_100, F_M2_5, F_ONE, F_12345_98), 1'b0,
               pk(32'd100, 32'hFFFFFFFE, 32'd1, 32'd12345), 3'b100);
    endtask

    task automatic t_exact;
        // R7 R4: exact values and boundary below the signed limit
        run_op("R7", pk(F_ONE, F_100, F_STOP, F_M2P31), 1'b0,
               pk(32'd1, 32'd100, 32'h7FFFFF80, 32'h80000000), 3'b000);
    endtask

    task automatic t_signed_sat;
        run_op("R4", pk(F_2P31, F_M2P32, F_PINF, F_NINF), 1'b0,
               pk(32'h7FFFFFFF, 32'h80000000, 32'h7FFFFFFF, 32'h80000000), 3'b001);
    endtask

    task automatic t_nan;
        run_op("R2", pk(F_QNAN, F_ONE, F_ONE, F_ONE), 1'b0,
               pk(32'h80000000, 32'd1, 32'd1, 32'd1), 3'b001);
        // R3 R9: signaling NaN in lane 3, inexact from lane 0
        run_op("R3", pk(F_12345_98, F_ONE, F_ONE, F_SNAN), 1'b0,
               pk(32'd12345, 32'd1, 32'd1, 32'h80000000), 3'b111);
    endtask

    task automatic t_unsigned;
        run_op("R5", pk(F_2P31, F_UTOP, F_2P32, F_PINF), 1'b1,
               pk(32'h80000000, 32'hFFFFFF00, 32'hFFFFFFFF, 32'hFFFFFFFF), 3'b001);
        run_op("R5", pk(F_MONE, F_QNAN, F_NINF, F_100), 1'b1,
               pk(32'd0, 32'd0, 32'd0, 32'd100), 3'b001);
        run_op("R5", pk(F_ONE, F_ONE, F_SNAN, F_ONE), 1'b1,
               pk(32'd1, 32'd1, 32'd0, 32'd1), 3'b011);
    endtask

    task automatic t_small_neg;
        run_op("R6", pk(F_MHALF, F_MZERO, F_DEN, F_ONE), 1'b1,
               pk(32'd0, 32'd0, 32'd0, 32'd1), 3'b100);
        run_op("R6", pk(F_MZERO, F_ONE, F_100, 32'h0), 1'b1,
               pk(32'd0, 32'd1, 32'd100, 32'd0), 3'b000);
    endtask

    task automatic t_zero_den;
        run_op("R8", pk(32'h0, F_MZERO, F_ONE, F_100), 1'b0,
               pk(32'd0, 32'd0, 32'd1, 32'd100), 3'b000);
        run_op("R8", pk(F_MDEN, 32'h0, F_ONE, F_ONE), 1'b0,
               pk(32'd0, 32'd0, 32'd1, 32'd1), 3'b100);
    endtask

    task automatic t_stream;
        logic [31:0] ops [4];
        logic [31:0] exps [4];
        ops[0] = F_ONE;      exps[0] = 32'd1;
        ops[1] = F_100;      exps[1] = 32'd100;
        ops[2] = F_12345_98; exps[2] = 32'd12345;
        ops[3] = F_2P31;     exps[3] = 32'h80000000;
        for (int j = 0; j < 6; j++) begin
            @(negedge clk);
            if (j >= 2) begin
                check("R10", 128'(out_valid), 128'(1'b1));
                check("R10", out_result, {4{exps[j-2]}});
            end
            if (j < 4) begin
                in_valid = 1'b1; in_uns = 1'b1; in_opnd = {4{ops[j]}};
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        check("R10", 128'(out_valid), 128'(1'b0));
    endtask

    task automatic t_stall;
        @(negedge clk);
        out_ready = 1'b0;
        in_valid = 1'b1; in_uns = 1'b0; in_opnd = {4{F_M2_5}};
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R10", 128'(out_valid), 128'(1'b1));
        check("R10", 128'(in_ready), 128'(1'b0));
        check("R10", out_result, {4{32'hFFFFFFFE}});
        check("R10", 128'(out_flags), 128'(3'b100));
        out_ready = 1'b1;
        @(negedge clk);
        check("R10", 128'(out_valid), 128'(1'b0));
        check("R11", 128'(in_ready), 128'(1'b1));
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_opnd = '0; in_uns = 1'b0; out_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_exact();
        t_signed_sat();
        t_nan();
        t_unsigned();
        t_small_neg();
        t_zero_den();
        t_stream();
        t_stall();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule